// File: doc/BRIEF.md
# Legacy Upper-Memory Attribute Map

This block steers processor memory accesses in the legacy upper-memory window (0xC0000 to 0xFFFFF). Software programs seven byte-wide attribute registers through a small byte-wide configuration port. Each register holds two 4-bit attribute fields, and each field controls one address segment. Each field has a read-enable bit and a write-enable bit, and the two bits act independently.

For every access presented on the memory side, the block decodes the 20-bit address in the same cycle. It then raises exactly one of two selects: one for DRAM, and one for the ROM/PCI forwarding path. For writes that may land in memory, it also raises a DRAM write strobe. Addresses below the window are plain DRAM accesses. The window is split into one 64 KB top segment and twelve 16 KB segments.

Top module: `legacy_attr_map`

## Requirements
- R1: After reset, all seven attribute registers (configuration offsets 0x59 to 0x5F) read as 0x00. Any other offset always reads 0x00.
- R2: Segment index n is held in the register at offset 0x59 + n/2. Even n uses bits [3:0] and odd n uses bits [7:4]. In each field, bit 0 is read enable and bit 1 is write enable.
- R3: A configuration write updates bits [3:0] only when `cfg_nib_en[0]` is 1, and bits [7:4] only when `cfg_nib_en[1]` is 1. The other nibble keeps its value.
- R4: Index 1 covers 0xF0000 to 0xFFFFF. Indices 2 to 13 cover 0xC0000 to 0xEFFFF in ascending 16 KB steps, so index k starts at 0xC0000 + (k-2)*0x4000.
- R5: A read inside a segment raises `dram_sel` when that segment's read enable is 1. It raises `rom_sel` when the read enable is 0.
- R6: A write inside a segment raises `dram_sel` and `dram_we` when that segment's write enable is 1. When the write enable is 0, it raises `rom_sel` and leaves `dram_we` low.
- R7: Accesses below 0xC0000 go to DRAM (`dram_sel`, and `dram_we` for writes) whatever the attribute registers hold. The reserved field (index 0, bits [3:0] of 0x59) is stored but affects no address.
- R8: With `mem_valid` low, all three outputs are low. With `mem_valid` high, exactly one of `dram_sel` and `rom_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_nib_en | input | 2 | Nibble enables for a configuration write |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| mem_valid | input | 1 | A memory access is presented |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 20 | Physical byte address |
| dram_sel | output | 1 | Access goes to DRAM |
| rom_sel | output | 1 | Access goes to the ROM/PCI path |
| dram_we | output | 1 | DRAM write strobe |

## Verification
The hardest case to reach is a field taking effect on exactly one segment without touching its neighbours. A wrong index, a swapped nibble, or an off-by-one segment boundary all look correct if every segment carries the same setting. The bench therefore enables one field at a time, probing the first and last byte of that segment and one address in every other segment. It then drives partial-nibble writes and the reserved field, and checks that neither disturbs the decode.

// File: rtl/legacy_attr_map.sv
module legacy_attr_map #(
  parameter int ADDR_W = 20,
  parameter int ATTR_REGS = 7,
  parameter logic [7:0] ATTR_BASE = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [1:0]        cfg_nib_en,
  output logic [7:0]        cfg_rdata,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              dram_sel,
  output logic              rom_sel,
  output logic              dram_we
);
  localparam int SEG_W = ADDR_W - 14;
  localparam logic [SEG_W-1:0] OPT_FIRST = SEG_W'((3 << (ADDR_W - 2)) >> 14);
  localparam logic [SEG_W-1:0] TOP_FIRST = SEG_W'((15 << (ADDR_W - 4)) >> 14);

  logic [7:0] attr [ATTR_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ATTR_REGS; i++) attr[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < ATTR_REGS; i++) begin
        if (cfg_addr == ATTR_BASE + 8'(i)) begin
          if (cfg_nib_en[0]) attr[i][3:0] <= cfg_wdata[3:0];
          if (cfg_nib_en[1]) attr[i][7:4] <= cfg_wdata[7:4];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < ATTR_REGS; i++)
      if (cfg_addr == ATTR_BASE + 8'(i)) cfg_rdata = attr[i];
  end

  wire [SEG_W-1:0] seg    = mem_addr[ADDR_W-1:14];
  wire             in_top = seg >= TOP_FIRST;
  wire             in_opt = (seg >= OPT_FIRST) && !in_top;
  wire             ctl    = in_top || in_opt;
  wire [3:0]       idx    = in_top ? 4'd1 : 4'd2 + 4'(seg - OPT_FIRST);

  logic [7:0] sel_reg;
  always_comb begin
    sel_reg = '0;
    for (int i = 0; i < ATTR_REGS; i++)
      if (idx[3:1] == 3'(i)) sel_reg = attr[i];
  end

  wire [3:0] field = idx[0] ? sel_reg[7:4] : sel_reg[3:0];
  wire       rd_ok = !ctl || field[0];
  wire       wr_ok = !ctl || field[1];
  wire       ok    = mem_write ? wr_ok : rd_ok;

  assign dram_sel = mem_valid && ok;
  assign rom_sel  = mem_valid && !ok;
  assign dram_we  = mem_valid && mem_write && wr_ok;
endmodule

module legacy_attr_map_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [1:0]  cfg_nib_en,
  input logic [7:0]  cfg_rdata,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [19:0] mem_addr,
  input logic        dram_sel,
  input logic        rom_sel,
  input logic        dram_we
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_rdata == 8'h00); // R1
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_nib_en == 2'b11 && cfg_addr >= 8'h59 && cfg_addr <= 8'h5F)
    |=> (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_wdata))); // R3
  AST_WE_NEEDS_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    dram_we |-> dram_sel && mem_write); // R6
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_addr < 20'hC0000) |-> dram_sel && dram_we == mem_write); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !dram_sel && !rom_sel && !dram_we); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $countones({dram_sel, rom_sel}) == 1); // R8
endmodule

bind legacy_attr_map legacy_attr_map_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_nib_en(cfg_nib_en), .cfg_rdata(cfg_rdata),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
  .dram_sel(dram_sel), .rom_sel(rom_sel), .dram_we(dram_we)
);

// File: tb/legacy_attr_map_test.sv
module legacy_attr_map_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0, cfg_wdata = 0;
  logic [1:0]  cfg_nib_en = 0;
  logic [7:0]  cfg_rdata;
  logic        mem_valid = 0, mem_write = 0;
  logic [19:0] mem_addr = 0;
  logic        dram_sel, rom_sel, dram_we;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  legacy_attr_map uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [7:0] d, logic [1:0] en);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; cfg_nib_en = en;
    @(negedge clk);
    cfg_we = 0; cfg_nib_en = 0;
  endtask

  task automatic cfg_rd(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, $sformatf("cfg[%h]", a), {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic acc(string req, logic [19:0] a, logic wr, logic e_dram, logic e_rom, logic e_we);
    @(negedge clk);
    mem_valid = 1; mem_write = wr; mem_addr = a;
    #1 chk(req, $sformatf("%s @%h", wr ? "wr" : "rd", a),
           {29'h0, dram_sel, rom_sel, dram_we}, {29'h0, e_dram, e_rom, e_we});
    @(negedge clk);
    mem_valid = 0;
  endtask

  function automatic logic [19:0] seg_base(int k);
    return (k == 1) ? 20'hF0000 : 20'hC0000 + 20'(k - 2) * 20'h4000;
  endfunction
  function automatic logic [19:0] seg_last(int k);
    return seg_base(k) + ((k == 1) ? 20'hFFFF : 20'h3FFF);
  endfunction

  task automatic t_reset;
    for (int r = 0; r < 7; r++) cfg_rd("R1", 8'h59 + 8'(r), 8'h00);
    cfg_rd("R1", 8'h58, 8'h00);
    cfg_rd("R1", 8'h60, 8'h00);
    acc("R5", 20'hC0000, 0, 0, 1, 0);
  endtask

  task automatic t_map;
    for (int k = 1; k <= 13; k++) begin
      cfg_wr(8'h59 + 8'(k / 2), 8'h11, (k % 2) ? 2'b10 : 2'b01);
      cfg_rd("R2", 8'h59 + 8'(k / 2), (k % 2) ? 8'h10 : 8'h01);
      acc("R4", seg_base(k), 0, 1, 0, 0);
      acc("R4", seg_last(k), 0, 1, 0, 0);
      for (int j = 1; j <= 13; j++)
        if (j != k) acc("R4", seg_base(j) + 20'h123, 0, 0, 1, 0);
      cfg_wr(8'h59 + 8'(k / 2), 8'h00, 2'b11);
    end
  endtask

  task automatic t_nibble;
    cfg_wr(8'h5C, 8'h32, 2'b11);
    cfg_rd("R3", 8'h5C, 8'h32);
    cfg_wr(8'h5C, 8'hF1, 2'b01);
    cfg_rd("R3", 8'h5C, 8'h31);
    cfg_wr(8'h5C, 8'h9E, 2'b10);
    cfg_rd("R3", 8'h5C, 8'h91);
    cfg_wr(8'h5C, 8'h77, 2'b00);
    cfg_rd("R3", 8'h5C, 8'h91);
    cfg_wr(8'h5C, 8'h00, 2'b11);
  endtask

  task automatic t_steer;
    cfg_wr(8'h5B, 8'h02, 2'b01);
    acc("R6", seg_base(4), 1, 1, 0, 1);
    acc("R5", seg_base(4), 0, 0, 1, 0);
    cfg_wr(8'h5B, 8'h01, 2'b01);
    acc("R6", seg_base(4), 1, 0, 1, 0);
    acc("R5", seg_last(4), 0, 1, 0, 0);
    cfg_wr(8'h5B, 8'h03, 2'b01);
    acc("R6", seg_last(4), 1, 1, 0, 1);
    acc("R5", seg_base(4), 0, 1, 0, 0);
    cfg_wr(8'h5B, 8'h00, 2'b01);
    acc("R6", seg_base(4), 1, 0, 1, 0);
    acc("R5", seg_base(4), 0, 0, 1, 0);
  endtask

  task automatic t_outside;
    cfg_wr(8'h59, 8'h03, 2'b11);
    cfg_rd("R7", 8'h59, 8'h03);
    acc("R7", 20'hF0000, 0, 0, 1, 0);
    acc("R7", 20'hFFFFF, 1, 0, 1, 0);
    acc("R7", 20'h00000, 1, 1, 0, 1);
    acc("R7", 20'hBFFFF, 0, 1, 0, 0);
    acc("R7", 20'hA0000, 1, 1, 0, 1);
    cfg_wr(8'h59, 8'h00, 2'b11);
  endtask

  task automatic t_idle;
    cfg_wr(8'h5F, 8'h33, 2'b11);
    @(negedge clk);
    mem_valid = 0; mem_write = 1; mem_addr = 20'hEC000;
    #1 chk("R8", "idle", {29'h0, dram_sel, rom_sel, dram_we}, 32'h0);
    acc("R8", 20'hEC000, 1, 1, 0, 1);
    cfg_wr(8'h5F, 8'h00, 2'b11);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_map;
    t_nibble;
    t_steer;
    t_outside;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule